// File: doc/BRIEF.md
# Chunked Asymmetric Product Accumulator

This block forms the full product of a long operand A (`NA_W` bits) and a shorter operand B (`NB_W` bits). It owns no wide multiplier. Instead it cuts both operands into `NC_W`-bit chunks and hands chunk pairs to an external fixed-width inner multiplier through a request/response handshake. It then folds every returned partial product into a word-organised accumulator. Chunk c of an operand covers bits `[c*NC_W +: NC_W]`. The top chunk may be only partly populated.

The block fetches every chunk of the short operand first and keeps them in a local store. It then streams the long operand past that store, one chunk at a time. Each long chunk is read once and paired with every stored short chunk in turn. The product of pair (i, j) lands at word offset i+j. Carries are added word by word into higher words until they are absorbed. When all products are in, the block writes out the result words, lowest first, and then pulses done.

Top module: `chunk_mul_accum`

## Requirements
- R1: While reset is held, and after it is released with no start, done, mul_req_valid, res_wr_en, a_rd_en and b_rd_en are all low.
- R2: After an accepted start, the block reads each of the NB_CH = ceil(NB_W/NC_W) short-operand chunks exactly once, before any long-operand read. Both read ports return data one cycle after the read enable.
- R3: Exactly NA_CH·NB_CH partial-product requests are issued per operation, with NA_CH = ceil(NA_W/NC_W). Request n (counted from 0) carries long chunk n div NB_CH on mul_op_a and short chunk n mod NB_CH on mul_op_b.
- R4: Each long-operand chunk is read exactly once per operation.
- R5: While mul_req_valid is high and mul_req_ready is low, the request stays valid and both operands stay unchanged.
- R6: The result is written as NA_CH+NB_CH words of NC_W bits on consecutive cycles, indices 0 upward. The concatenated words equal A·B exactly.
- R7: Bits of the top chunk above the operand's width (above bit NA_W-1 of A or NB_W-1 of B) have no effect on the requests or the result.
- R8: Carries are fully absorbed before output begins. done is a single-cycle pulse in the cycle after the last result write.
- R9: A start asserted while an operation is running is ignored: no extra reads, requests, writes or done pulses follow from it.
- R10: The result is independent of how long the inner multiplier withholds mul_req_ready and of its response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| done | output | 1 | One-cycle pulse after the last result word |
| b_rd_en | output | 1 | Short-operand chunk read strobe |
| b_rd_idx | output | BI_W | Short-operand chunk index |
| b_rd_data | input | NC_W | Short-operand chunk, one cycle after the strobe |
| a_rd_en | output | 1 | Long-operand chunk read strobe |
| a_rd_idx | output | AI_W | Long-operand chunk index |
| a_rd_data | input | NC_W | Long-operand chunk, one cycle after the strobe |
| mul_req_valid | output | 1 | Partial-product request valid |
| mul_req_ready | input | 1 | Inner multiplier accepts the request |
| mul_op_a | output | NC_W | Long-operand chunk of the request |
| mul_op_b | output | NC_W | Short-operand chunk of the request |
| mul_rsp_valid | input | 1 | Partial product available |
| mul_rsp_data | input | 2·NC_W | Partial product |
| res_wr_en | output | 1 | Result word write strobe |
| res_wr_idx | output | RI_W | Result word index |
| res_wr_data | output | NC_W | Result word |

## Verification
The bench builds the block with NA_W = 72, NB_W = 40 and NC_W = 16. This gives five long chunks, three short chunks and eight result words. With these values both top chunks are only half populated, so the masking of stray upper bits can be tested. The short operand also spans several inner-multiplier blocks, so every long chunk is reused against three stored chunks. All-ones operands drive carries across several words in a row. The stand-in multiplier varies its ready and response delay at random, which exercises the handshake hold rule and shows the result does not depend on timing.

// File: rtl/cma_pkg.sv
package cma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LB_REQ,
        ST_LB_CAP,
        ST_LA_REQ,
        ST_LA_CAP,
        ST_MREQ,
        ST_MWAIT,
        ST_RIPPLE,
        ST_WRITE
    } cma_state_e;

endpackage

// File: rtl/cma_chunk_mask.sv
module cma_chunk_mask #(
    parameter int NC_W    = 16,
    parameter int VALID_W = 16
) (
    input  logic [NC_W-1:0] in_word,
    input  logic            is_top,
    output logic [NC_W-1:0] out_word
);
    localparam logic [NC_W-1:0] KEEP = {NC_W{1'b1}} >> (NC_W - VALID_W);

    // the top chunk keeps only its populated low bits
    assign out_word = is_top ? (in_word & KEEP) : in_word;

    initial begin
        a_valid_w_range: assert (VALID_W >= 1 && VALID_W <= NC_W);
    end
endmodule

// File: rtl/cma_word_add.sv
module cma_word_add #(
    parameter int W = 16
) (
    input  logic [2*W-1:0] x,
    input  logic [2*W-1:0] y,
    output logic [2*W-1:0] sum,
    output logic           cout
);
    assign {cout, sum} = {1'b0, x} + {1'b0, y};
endmodule

// File: rtl/chunk_mul_accum.sv
module chunk_mul_accum
    import cma_pkg::*;
#(
    parameter int NA_W = 72,
    parameter int NB_W = 40,
    parameter int NC_W = 16,
    localparam int NA_CH  = (NA_W + NC_W - 1) / NC_W,
    localparam int NB_CH  = (NB_W + NC_W - 1) / NC_W,
    localparam int RES_CH = NA_CH + NB_CH,
    localparam int AI_W   = (NA_CH > 1) ? $clog2(NA_CH) : 1,
    localparam int BI_W   = (NB_CH > 1) ? $clog2(NB_CH) : 1,
    localparam int RI_W   = $clog2(RES_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              b_rd_en,
    output logic [BI_W-1:0]   b_rd_idx,
    input  logic [NC_W-1:0]   b_rd_data,
    output logic              a_rd_en,
    output logic [AI_W-1:0]   a_rd_idx,
    input  logic [NC_W-1:0]   a_rd_data,
    output logic              mul_req_valid,
    input  logic              mul_req_ready,
    output logic [NC_W-1:0]   mul_op_a,
    output logic [NC_W-1:0]   mul_op_b,
    input  logic              mul_rsp_valid,
    input  logic [2*NC_W-1:0] mul_rsp_data,
    output logic              res_wr_en,
    output logic [RI_W-1:0]   res_wr_idx,
    output logic [NC_W-1:0]   res_wr_data
);
    localparam int A_TOP_W = NA_W - (NA_CH - 1) * NC_W;
    localparam int B_TOP_W = NB_W - (NB_CH - 1) * NC_W;
    localparam logic [AI_W-1:0] A_LAST  = AI_W'(NA_CH - 1);
    localparam logic [BI_W-1:0] B_LAST  = BI_W'(NB_CH - 1);
    localparam logic [RI_W-1:0] W_LAST  = RI_W'(RES_CH - 1);
    localparam logic [RI_W:0]   RES_LIM = (RI_W + 1)'(RES_CH);

    typedef struct packed {
        cma_state_e                    st;
        logic [AI_W-1:0]               ai;
        logic [BI_W-1:0]               bj;
        logic [RI_W-1:0]               w;
        logic [NC_W-1:0]               a_word;
        logic [NB_CH-1:0][NC_W-1:0]    b_store;
        logic [RES_CH-1:0][NC_W-1:0]   acc;
        logic                          done;
    } regs_t;

    regs_t r_q, r_d;

    logic [NC_W-1:0]   a_masked, b_masked;
    logic [RI_W:0]     k_pos, k_plus2;
    logic [RI_W-1:0]   k_idx;
    logic [2*NC_W-1:0] add_x, add_y, add_sum;
    logic              add_cout;
    logic              advance;

    cma_chunk_mask #(.NC_W(NC_W), .VALID_W(A_TOP_W)) u_mask_a (
        .in_word (a_rd_data),
        .is_top  (r_q.ai == A_LAST),
        .out_word(a_masked)
    );

    cma_chunk_mask #(.NC_W(NC_W), .VALID_W(B_TOP_W)) u_mask_b (
        .in_word (b_rd_data),
        .is_top  (r_q.bj == B_LAST),
        .out_word(b_masked)
    );

    cma_word_add #(.W(NC_W)) u_add (
        .x   (add_x),
        .y   (add_y),
        .sum (add_sum),
        .cout(add_cout)
    );

    // word offset of the current chunk pair
    assign k_pos   = (RI_W + 1)'(r_q.ai) + (RI_W + 1)'(r_q.bj);
    assign k_plus2 = k_pos + (RI_W + 1)'(2);
    assign k_idx   = k_pos[RI_W-1:0];

    always_comb begin
        if (r_q.st == ST_RIPPLE) begin
            add_x = {{NC_W{1'b0}}, r_q.acc[r_q.w]};
            add_y = (2 * NC_W)'(1);
        end else begin
            add_x = {r_q.acc[k_idx + RI_W'(1)], r_q.acc[k_idx]};
            add_y = mul_rsp_data;
        end
    end

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        advance = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.acc = '0;
                    r_d.ai  = '0;
                    r_d.bj  = '0;
                    r_d.w   = '0;
                    r_d.st  = ST_LB_REQ;
                end
            end
            ST_LB_REQ: r_d.st = ST_LB_CAP;
            ST_LB_CAP: begin
                r_d.b_store[r_q.bj] = b_masked;
                if (r_q.bj == B_LAST) begin
                    r_d.bj = '0;
                    r_d.st = ST_LA_REQ;
                end else begin
                    r_d.bj = r_q.bj + BI_W'(1);
                    r_d.st = ST_LB_REQ;
                end
            end
            ST_LA_REQ: r_d.st = ST_LA_CAP;
            ST_LA_CAP: begin
                r_d.a_word = a_masked;
                r_d.st     = ST_MREQ;
            end
            ST_MREQ: begin
                if (mul_req_ready) r_d.st = ST_MWAIT;
            end
            ST_MWAIT: begin
                if (mul_rsp_valid) begin
                    r_d.acc[k_idx]              = add_sum[NC_W-1:0];
                    r_d.acc[k_idx + RI_W'(1)]   = add_sum[2*NC_W-1:NC_W];
                    if (add_cout && (k_plus2 < RES_LIM)) begin
                        r_d.w  = k_plus2[RI_W-1:0];
                        r_d.st = ST_RIPPLE;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_RIPPLE: begin
                r_d.acc[r_q.w] = add_sum[NC_W-1:0];
                if (add_sum[NC_W] && (r_q.w != W_LAST)) begin
                    r_d.w = r_q.w + RI_W'(1);
                end else begin
                    advance = 1'b1;
                end
            end
            ST_WRITE: begin
                if (r_q.w == W_LAST) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.w = r_q.w + RI_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (advance) begin
            if (r_q.bj != B_LAST) begin
                r_d.bj = r_q.bj + BI_W'(1);
                r_d.st = ST_MREQ;
            end else if (r_q.ai != A_LAST) begin
                r_d.bj = '0;
                r_d.ai = r_q.ai + AI_W'(1);
                r_d.st = ST_LA_REQ;
            end else begin
                r_d.bj = '0;
                r_d.w  = '0;
                r_d.st = ST_WRITE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done          = r_q.done;
    assign b_rd_en       = (r_q.st == ST_LB_REQ);
    assign b_rd_idx      = r_q.bj;
    assign a_rd_en       = (r_q.st == ST_LA_REQ);
    assign a_rd_idx      = r_q.ai;
    assign mul_req_valid = (r_q.st == ST_MREQ);
    assign mul_op_a      = r_q.a_word;
    assign mul_op_b      = r_q.b_store[r_q.bj];
    assign res_wr_en     = (r_q.st == ST_WRITE);
    assign res_wr_idx    = r_q.w;
    assign res_wr_data   = r_q.acc[r_q.w];

    // request counter used only by the checks below
    logic [15:0] req_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_cnt_q <= '0;
        end else if (r_q.st == ST_IDLE && start) begin
            req_cnt_q <= '0;
        end else if (mul_req_valid && mul_req_ready) begin
            req_cnt_q <= req_cnt_q + 16'd1;
        end
    end

    p_hold_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_req_valid && !mul_req_ready) |=>
            (mul_req_valid && $stable(mul_op_a) && $stable(mul_op_b)));

    p_no_lost_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MWAIT && mul_rsp_valid && add_cout) |-> (k_plus2 < RES_LIM));

    p_no_ripple_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RIPPLE && add_sum[NC_W]) |-> (r_q.w != W_LAST));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_en |=> ((res_wr_en && res_wr_idx == $past(res_wr_idx) + RI_W'(1)) || done));

    p_request_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_cnt_q == 16'(NA_CH * NB_CH)));

    p_reads_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_rd_en && b_rd_en));
endmodule

// File: tb/chunk_mul_accum_test.sv
module chunk_mul_accum_test;
    localparam int NA_W = 72, NB_W = 40, NC_W = 16;
    localparam int NA_CH = 5, NB_CH = 3, RES_CH = 8, RES_W = 128;
    localparam logic [NC_W-1:0] A_TOP_KEEP = 16'h00FF;
    localparam logic [NC_W-1:0] B_TOP_KEEP = 16'h00FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, b_rd_en, a_rd_en, mul_req_valid, res_wr_en;
    logic [1:0] b_rd_idx;
    logic [2:0] a_rd_idx, res_wr_idx;
    logic [NC_W-1:0] b_rd_data, a_rd_data, mul_op_a, mul_op_b, res_wr_data;
    logic mul_req_ready, mul_rsp_valid;
    logic [2*NC_W-1:0] mul_rsp_data;

    always #4 clk = ~clk;

    chunk_mul_accum #(.NA_W(NA_W), .NB_W(NB_W), .NC_W(NC_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .b_rd_en(b_rd_en), .b_rd_idx(b_rd_idx), .b_rd_data(b_rd_data),
        .a_rd_en(a_rd_en), .a_rd_idx(a_rd_idx), .a_rd_data(a_rd_data),
        .mul_req_valid(mul_req_valid), .mul_req_ready(mul_req_ready),
        .mul_op_a(mul_op_a), .mul_op_b(mul_op_b),
        .mul_rsp_valid(mul_rsp_valid), .mul_rsp_data(mul_rsp_data),
        .res_wr_en(res_wr_en), .res_wr_idx(res_wr_idx), .res_wr_data(res_wr_data)
    );

    logic [NC_W-1:0] a_mem [NA_CH];
    logic [NC_W-1:0] b_mem [NB_CH];
    logic [NC_W-1:0] exp_a [NA_CH];
    logic [NC_W-1:0] exp_b [NB_CH];
    logic [NC_W-1:0] res_buf [RES_CH];

    // operand memories, one-cycle read latency
    always @(posedge clk) begin
        if (a_rd_en) a_rd_data <= a_mem[a_rd_idx];
        if (b_rd_en) b_rd_data <= b_mem[b_rd_idx];
    end

    // stand-in inner multiplier with random ready and latency
    logic            mp_pend;
    logic [2*NC_W-1:0] mp_prod;
    int              mp_delay;
    always @(posedge clk) begin
        if (!rst_n) begin
            mul_req_ready <= 1'b0;
            mul_rsp_valid <= 1'b0;
            mul_rsp_data  <= '0;
            mp_pend       <= 1'b0;
            mp_delay      <= 0;
        end else begin
            mul_req_ready <= ($urandom % 4) != 0;
            mul_rsp_valid <= 1'b0;
            if (mp_pend) begin
                if (mp_delay == 0) begin
                    mul_rsp_valid <= 1'b1;
                    mul_rsp_data  <= mp_prod;
                    mp_pend       <= 1'b0;
                end else begin
                    mp_delay <= mp_delay - 1;
                end
            end
            if (mul_req_valid && mul_req_ready) begin
                mp_pend  <= 1'b1;
                mp_prod  <= mul_op_a * mul_op_b;
                mp_delay <= int'($urandom % 4);
            end
        end
    end

    // port monitor
    int cyc = 0, b_rd_cnt = 0, a_rd_cnt = 0, req_cnt = 0, req_in_op = 0;
    int order_err = 0, hold_err = 0, b_after_a = 0, wr_cnt = 0, wr_ord_err = 0;
    int done_cnt = 0, done_cyc = 0, last_wr_cyc = 0;
    logic a_seen = 1'b0, prev_blocked = 1'b0, prev_wr_en = 1'b0;
    logic [NC_W-1:0] prev_a, prev_b;
    logic [2:0] prev_wr_idx;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            prev_blocked <= 1'b0;
            prev_wr_en   <= 1'b0;
            a_seen       <= 1'b0;
            req_in_op    <= 0;
        end else begin
            if (b_rd_en) begin
                b_rd_cnt <= b_rd_cnt + 1;
                if (a_seen) b_after_a <= b_after_a + 1;
            end
            if (a_rd_en) begin
                a_rd_cnt <= a_rd_cnt + 1;
                a_seen   <= 1'b1;
            end
            if (prev_blocked && (!mul_req_valid || mul_op_a != prev_a || mul_op_b != prev_b))
                hold_err <= hold_err + 1;
            prev_blocked <= mul_req_valid && !mul_req_ready;
            prev_a <= mul_op_a;
            prev_b <= mul_op_b;
            if (mul_req_valid && mul_req_ready) begin
                req_cnt   <= req_cnt + 1;
                req_in_op <= req_in_op + 1;
                if (req_in_op >= NA_CH * NB_CH ||
                    mul_op_a != exp_a[req_in_op / NB_CH] ||
                    mul_op_b != exp_b[req_in_op % NB_CH])
                    order_err <= order_err + 1;
            end
            if (res_wr_en) begin
                res_buf[res_wr_idx] <= res_wr_data;
                wr_cnt      <= wr_cnt + 1;
                last_wr_cyc <= cyc;
                if (prev_wr_en && res_wr_idx != prev_wr_idx + 3'd1)
                    wr_ord_err <= wr_ord_err + 1;
            end
            prev_wr_en  <= res_wr_en;
            prev_wr_idx <= res_wr_idx;
            if (done) begin
                done_cnt  <= done_cnt + 1;
                done_cyc  <= cyc;
                a_seen    <= 1'b0;
                req_in_op <= 0;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [RES_W-1:0] act, input logic [RES_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc == 190000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
            $finish;
        end
    end

    task automatic run_op(input logic [NA_W-1:0] a, input logic [NB_W-1:0] b,
                          input bit garbage, input bit restart, input string tag);
        logic [NA_CH*NC_W-1:0] ax;
        logic [NB_CH*NC_W-1:0] bx;
        logic [RES_W-1:0] ref_p, got;
        int b0, a0, r0, oe0, he0, ba0, w0, wo0, d0, t;
        ax = (NA_CH*NC_W)'(a);
        bx = (NB_CH*NC_W)'(b);
        for (int c = 0; c < NA_CH; c++) begin
            exp_a[c] = ax[c*NC_W +: NC_W];
            a_mem[c] = exp_a[c];
        end
        for (int c = 0; c < NB_CH; c++) begin
            exp_b[c] = bx[c*NC_W +: NC_W];
            b_mem[c] = exp_b[c];
        end
        if (garbage) begin
            a_mem[NA_CH-1] = exp_a[NA_CH-1] | (NC_W'($urandom) & ~A_TOP_KEEP) | 16'h8000;
            b_mem[NB_CH-1] = exp_b[NB_CH-1] | (NC_W'($urandom) & ~B_TOP_KEEP) | 16'h8000;
        end
        ref_p = RES_W'(a) * RES_W'(b);
        b0 = b_rd_cnt; a0 = a_rd_cnt; r0 = req_cnt; oe0 = order_err; he0 = hold_err;
        ba0 = b_after_a; w0 = wr_cnt; wo0 = wr_ord_err; d0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (restart) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        t = 0;
        while (done_cnt == d0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(t < 3000, {tag, " watchdog"}, RES_W'(t), 0);
        repeat (restart ? 40 : 2) @(negedge clk);
        for (int c = 0; c < RES_CH; c++) got[c*NC_W +: NC_W] = res_buf[c];
        check(got == ref_p, {tag, " R6 R10 product"}, got, ref_p);
        check(b_rd_cnt - b0 == NB_CH && b_after_a == ba0, {tag, " R2 short reads first"},
              RES_W'(b_rd_cnt - b0), NB_CH);
        check(a_rd_cnt - a0 == NA_CH, {tag, " R4 long reads"}, RES_W'(a_rd_cnt - a0), NA_CH);
        check(req_cnt - r0 == NA_CH * NB_CH, {tag, " R3 request count"},
              RES_W'(req_cnt - r0), NA_CH * NB_CH);
        check(order_err == oe0, {tag, " R3 R7 request operands"}, RES_W'(order_err - oe0), 0);
        check(hold_err == he0, {tag, " R5 hold"}, RES_W'(hold_err - he0), 0);
        check(wr_cnt - w0 == RES_CH && wr_ord_err == wo0, {tag, " R6 write sequence"},
              RES_W'(wr_cnt - w0), RES_CH);
        check(done_cnt - d0 == 1 && done_cyc == last_wr_cyc + 1, {tag, " R8 R9 done timing"},
              RES_W'(done_cyc), RES_W'(last_wr_cyc + 1));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(!done && !mul_req_valid && !res_wr_en && !a_rd_en && !b_rd_en,
              "R1 in reset", {done, mul_req_valid, res_wr_en, a_rd_en, b_rd_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!done && !mul_req_valid && !res_wr_en && !a_rd_en && !b_rd_en,
              "R1 idle after reset", {done, mul_req_valid, res_wr_en, a_rd_en, b_rd_en}, 0);

        run_op('0, '0, 1'b0, 1'b0, "zero");
        run_op('1, '1, 1'b0, 1'b0, "all ones carry");
        run_op('1, '1, 1'b1, 1'b0, "R7 stray top bits");
        run_op(NA_W'(1), NB_W'(1), 1'b1, 1'b0, "one by one");
        run_op('1, NB_W'(1), 1'b0, 1'b0, "max by one");
        run_op(NA_W'(1) << (NA_W - 1), NB_W'(1) << (NB_W - 1), 1'b0, 1'b0, "top bits");
        run_op(NA_W'({$urandom, $urandom, $urandom}), NB_W'({$urandom, $urandom}),
               1'b0, 1'b1, "R9 restart ignored");
        for (int n = 0; n < 25; n++) begin
            run_op(NA_W'({$urandom, $urandom, $urandom}), NB_W'({$urandom, $urandom}),
                   n[0], 1'b0, "R10 random");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule